// File: doc/BRIEF.md
# Interleaved Rounding Incrementer with Exponent Adjust

This block is the last arithmetic step on the non-cancelling path of a floating-point adder. Each operation brings a significand, a biased exponent, a round-up bit decided upstream, and a two-bit code that says whether the exponent steps up, steps down or passes through. The block returns the rounded significand and the final exponent. An input that overflows the exponent range comes back with an all-ones exponent and an overflow flag.

The significand is incremented by a ripple incrementer that works one base-4 digit per cycle. It stops as soon as the carry dies out, so common operands finish in a few cycles and only long runs of ones take the full width. Two such incrementers take operations in turn. A merge stage returns results in the order they were accepted, so a long ripple in one lane does not reorder the stream. The exponent path computes the adjusted exponent and that value plus one side by side when an operation is accepted. The significand carry-out then only picks one of them.

Top module: `rinc_top`

## Requirements
- R1: Input and output both use valid/ready handshakes. While `out_valid` is high and `out_ready` is low, `out_valid`, `out_sig`, `out_exp` and `out_ovf` hold their values.
- R2: Accepted operations go to the two incrementer lanes in strict alternation. `in_ready` is low while the lane due next is still occupied, so at most two operations are in flight.
- R3: Results leave in the order their operations were accepted, and `out_valid` never rises without a pending operation.
- R4: `out_sig` equals the input significand plus the round-up bit. With the round-up bit at 0 the significand is returned unchanged.
- R5: When every significand bit is 1 and the round-up bit is 1, `out_sig` has only its most significant bit set and the exponent takes the plus-one value.
- R6: Exponent code `in_adj`: 2'b01 adds one, 2'b10 subtracts one, 2'b00 passes the exponent unchanged. Decrementing an exponent of 0 leaves 0. Code 2'b11 is illegal and must never be presented.
- R7: If the final exponent (adjusted, plus one on significand carry-out) reaches or passes 2047, `out_exp` is 2047 (all ones) and `out_ovf` is 1. Otherwise `out_ovf` is 0.
- R8: With the lane free and `out_ready` high, an operation with round-up 0 shows `out_valid` right after its accept edge. With round-up 1 it shows after d further edges. Here d is one plus the number of consecutive base-4 digits equal to 3, counted from the least significant digit (bits 1:0) upward, with a maximum of 27.
- R9: After reset `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Operation accepted this cycle when high with in_valid |
| in_sig | input | SIG_W (53) | Significand before rounding |
| in_exp | input | EXP_W (11) | Biased exponent before adjustment |
| in_rup | input | 1 | Round-up bit, carry-in of the incrementer |
| in_adj | input | 2 | Exponent code: 01 up, 10 down, 00 pass |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer takes the result when high with out_valid |
| out_sig | output | SIG_W (53) | Rounded significand |
| out_exp | output | EXP_W (11) | Final exponent, saturated to all ones |
| out_ovf | output | 1 | Exponent overflow flag |

## Verification
The bench builds the block with its default widths, a 53-bit significand and an 11-bit exponent. These widths give 27 base-4 digits, so an all-ones significand drives the carry through the full ripple length. They also make the saturation threshold 2047, which exponents near the top of the range reach directly. Directed cases measure the per-digit latency and the exponent corner cases. A long random stream with random output stalls mixes short and long ripples across both lanes, so one lane often finishes before the other and the in-order merge is exercised.

// File: rtl/rinc_pkg.sv
package rinc_pkg;

    typedef enum logic [1:0] {
        LANE_IDLE = 2'd0,
        LANE_RUN  = 2'd1,
        LANE_DONE = 2'd2
    } lane_st_e;

    localparam logic [1:0] ADJ_PASS = 2'b00;
    localparam logic [1:0] ADJ_UP   = 2'b01;
    localparam logic [1:0] ADJ_DOWN = 2'b10;

    localparam int RADIX_BITS = 2;
    localparam int NUM_LANES  = 2;

endpackage

// File: rtl/rinc_exp_adjust.sv
module rinc_exp_adjust #(
    parameter int EXP_W = 11
) (
    input  logic [EXP_W-1:0] exp_i,
    input  logic [1:0]       code_i,
    output logic [EXP_W:0]   base_o,
    output logic [EXP_W:0]   plus1_o
);
    import rinc_pkg::*;

    localparam logic [EXP_W:0] ONE = (EXP_W+1)'(1);
    localparam logic [EXP_W:0] TWO = (EXP_W+1)'(2);

    logic [EXP_W:0] ext;
    logic           is_zero;

    // Two independent chains: adjusted value and adjusted value plus one.
    always_comb begin
        ext     = {1'b0, exp_i};
        is_zero = (exp_i == '0);
        case (code_i)
            ADJ_UP: begin
                base_o  = ext + ONE;
                plus1_o = ext + TWO;
            end
            ADJ_DOWN: begin
                base_o  = is_zero ? '0  : ext - ONE;
                plus1_o = is_zero ? ONE : ext;
            end
            default: begin
                base_o  = ext;
                plus1_o = ext + ONE;
            end
        endcase
    end

endmodule

// File: rtl/rinc_lane.sv
module rinc_lane #(
    parameter int SIG_W = 53,
    parameter int EXP_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [SIG_W-1:0] ld_sig,
    input  logic             ld_rup,
    input  logic [EXP_W:0]   ld_base,
    input  logic [EXP_W:0]   ld_plus1,
    input  logic             pop,
    output logic             busy,
    output logic             done,
    output logic [SIG_W-1:0] res_sig,
    output logic [EXP_W-1:0] res_exp,
    output logic             res_ovf
);
    import rinc_pkg::*;

    localparam int NDIG  = (SIG_W + RADIX_BITS) / RADIX_BITS;
    localparam int PAD_W = NDIG * RADIX_BITS;
    localparam int IDX_W = (NDIG > 1) ? $clog2(NDIG) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NDIG - 1);
    localparam logic [EXP_W:0]   EXP_SAT  = {1'b0, {EXP_W{1'b1}}};

    typedef struct packed {
        lane_st_e             st;
        logic [PAD_W-1:0]     pad;
        logic [IDX_W-1:0]     idx;
        logic [EXP_W:0]       base;
        logic [EXP_W:0]       plus1;
    } lane_s;

    lane_s q, d;
    logic [RADIX_BITS-1:0] dig;
    logic                  cout;
    logic [EXP_W:0]        e_sel;

    always_comb begin
        d   = q;
        dig = q.pad[q.idx*RADIX_BITS +: RADIX_BITS];
        case (q.st)
            LANE_IDLE: begin
                if (load) begin
                    d.pad   = PAD_W'(ld_sig);
                    d.idx   = '0;
                    d.base  = ld_base;
                    d.plus1 = ld_plus1;
                    d.st    = ld_rup ? LANE_RUN : LANE_DONE;
                end
            end
            LANE_RUN: begin
                d.pad[q.idx*RADIX_BITS +: RADIX_BITS] = dig + RADIX_BITS'(1);
                if ((dig == '1) && (q.idx != LAST_IDX)) begin
                    d.idx = q.idx + IDX_W'(1);
                end else begin
                    d.st = LANE_DONE;
                end
            end
            LANE_DONE: begin
                if (pop) begin
                    d.st = LANE_IDLE;
                end
            end
            default: d.st = LANE_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        busy    = (q.st != LANE_IDLE);
        done    = (q.st == LANE_DONE);
        cout    = q.pad[SIG_W];
        res_sig = cout ? {1'b1, {(SIG_W-1){1'b0}}} : q.pad[SIG_W-1:0];
        e_sel   = cout ? q.plus1 : q.base;
        res_ovf = (e_sel >= EXP_SAT);
        res_exp = res_ovf ? {EXP_W{1'b1}} : e_sel[EXP_W-1:0];
    end

endmodule

// File: rtl/rinc_top.sv
module rinc_top #(
    parameter int SIG_W = 53,
    parameter int EXP_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [SIG_W-1:0] in_sig,
    input  logic [EXP_W-1:0] in_exp,
    input  logic             in_rup,
    input  logic [1:0]       in_adj,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [SIG_W-1:0] out_sig,
    output logic [EXP_W-1:0] out_exp,
    output logic             out_ovf
);
    import rinc_pkg::*;

    typedef struct packed {
        logic wr;
        logic rd;
    } ptr_s;

    ptr_s q, d;

    logic [EXP_W:0]   adj_base;
    logic [EXP_W:0]   adj_plus1;
    logic             acc;
    logic             rel;

    logic [NUM_LANES-1:0] ln_load;
    logic [NUM_LANES-1:0] ln_pop;
    logic [NUM_LANES-1:0] ln_busy;
    logic [NUM_LANES-1:0] ln_done;
    logic [SIG_W-1:0]     ln_sig [NUM_LANES];
    logic [EXP_W-1:0]     ln_exp [NUM_LANES];
    logic [NUM_LANES-1:0] ln_ovf;

    rinc_exp_adjust #(.EXP_W(EXP_W)) u_exp (
        .exp_i   (in_exp),
        .code_i  (in_adj),
        .base_o  (adj_base),
        .plus1_o (adj_plus1)
    );

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        assign ln_load[g] = acc && (q.wr == 1'(g));
        assign ln_pop[g]  = rel && (q.rd == 1'(g));

        rinc_lane #(.SIG_W(SIG_W), .EXP_W(EXP_W)) u_lane (
            .clk      (clk),
            .rst_n    (rst_n),
            .load     (ln_load[g]),
            .ld_sig   (in_sig),
            .ld_rup   (in_rup),
            .ld_base  (adj_base),
            .ld_plus1 (adj_plus1),
            .pop      (ln_pop[g]),
            .busy     (ln_busy[g]),
            .done     (ln_done[g]),
            .res_sig  (ln_sig[g]),
            .res_exp  (ln_exp[g]),
            .res_ovf  (ln_ovf[g])
        );
    end

    always_comb begin
        in_ready  = !ln_busy[q.wr];
        out_valid = ln_done[q.rd];
        out_sig   = ln_sig[q.rd];
        out_exp   = ln_exp[q.rd];
        out_ovf   = ln_ovf[q.rd];
        acc       = in_valid && in_ready;
        rel       = out_valid && out_ready;
        d         = q;
        if (acc) d.wr = !q.wr;
        if (rel) d.rd = !q.rd;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

endmodule

// File: rtl/rinc_checker.sv
module rinc_checker #(
    parameter int SIG_W = 53,
    parameter int EXP_W = 11
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             in_ready,
    input logic [1:0]       in_adj,
    input logic             out_valid,
    input logic             out_ready,
    input logic [SIG_W-1:0] out_sig,
    input logic [EXP_W-1:0] out_exp,
    input logic             out_ovf
);
    logic [1:0] pend_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
        end else begin
            case ({in_valid && in_ready, out_valid && out_ready})
                2'b10:   pend_q <= pend_q + 2'd1;
                2'b01:   pend_q <= pend_q - 2'd1;
                default: pend_q <= pend_q;
            endcase
        end
    end

    a_r1_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_sig)
                                    && $stable(out_exp) && $stable(out_ovf));

    a_r2_at_most_two: assert property (@(posedge clk) disable iff (!rst_n)
        pend_q <= 2'd2);

    a_r2_full_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        pend_q == 2'd2 |-> !in_ready);

    a_r3_no_phantom: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> pend_q != 2'd0);

    a_r6_code_legal: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> in_adj != 2'b11);

    a_r7_saturated: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_ovf |-> out_exp == {EXP_W{1'b1}});

endmodule

bind rinc_top rinc_checker #(.SIG_W(SIG_W), .EXP_W(EXP_W)) u_chk (.*);

// File: tb/rinc_top_bench.sv
module rinc_top_bench;
    localparam int CLK_PERIOD = 10;
    localparam int SW    = 53;
    localparam int EW    = 11;
    localparam int ENT_W = SW + EW + 1;
    localparam int EMAX  = (1 << EW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [SW-1:0] in_sig = '0;
    logic [EW-1:0] in_exp = '0;
    logic          in_rup = 1'b0;
    logic [1:0]    in_adj = 2'b00;
    logic          out_valid;
    logic          out_ready = 1'b1;
    logic [SW-1:0] out_sig;
    logic [EW-1:0] out_exp;
    logic          out_ovf;

    int    checks = 0;
    int    fails = 0;
    bit    finished = 0;
    int    rdy_mode = 1;
    string cur_req = "R4";

    logic [ENT_W-1:0] exp_q[$];
    logic             stall_prev = 1'b0;
    logic [ENT_W-1:0] held = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rinc_top #(.SIG_W(SW), .EXP_W(EW)) u_rinc_top (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready),
        .in_sig(in_sig), .in_exp(in_exp), .in_rup(in_rup), .in_adj(in_adj),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_sig(out_sig), .out_exp(out_exp), .out_ovf(out_ovf)
    );

    function automatic logic [ENT_W-1:0] model(logic [SW-1:0] s_in, logic [EW-1:0] e_in,
                                               logic r, logic [1:0] a);
        logic [SW:0] s;
        logic        c;
        int          e;
        logic        o;
        s = {1'b0, s_in} + (SW+1)'(r);
        c = s[SW];
        if (c) s = {2'b01, {(SW-1){1'b0}}};
        e = int'(e_in);
        if (a == 2'b01) e = e + 1;
        else if (a == 2'b10 && e > 0) e = e - 1;
        if (c) e = e + 1;
        o = (e >= EMAX);
        if (o) e = EMAX;
        return {s[SW-1:0], EW'(e), o};
    endfunction

    function automatic int digits(logic [SW-1:0] s);
        int n = 1;
        for (int i = 0; i < (SW + 2) / 2 - 1; i++) begin
            if (s[2*i +: 2] != 2'b11) break;
            n++;
        end
        return n;
    endfunction

    task automatic check(bit ok, string req, string what, logic [63:0] act, logic [63:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    // Reference model: push on accept, compare on delivery, track stalls.
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (in_valid && in_ready) exp_q.push_back(model(in_sig, in_exp, in_rup, in_adj));
            if (stall_prev) begin
                check(out_valid && ({out_sig, out_exp, out_ovf} == held), "R1", "held result",
                      64'({out_sig, out_exp, out_ovf}), 64'(held));
            end
            if (out_valid) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R3", "output with nothing pending", 64'(out_sig), 64'(0));
                end else if (out_ready) begin
                    check({out_sig, out_exp, out_ovf} == exp_q[0], cur_req, "result",
                          64'({out_sig, out_exp, out_ovf}), 64'(exp_q[0]));
                    if ({out_sig, out_exp, out_ovf} != exp_q[0])
                        $display("     exp %0d/%0d ovf %0d/%0d", out_exp,
                                 exp_q[0][EW:1], out_ovf, exp_q[0][0]);
                    void'(exp_q.pop_front());
                end
            end
            stall_prev = out_valid && !out_ready;
            held       = {out_sig, out_exp, out_ovf};
        end
    end

    initial begin
        forever begin
            @(posedge clk);
            #1;
            case (rdy_mode)
                0:       out_ready = 1'b0;
                1:       out_ready = 1'b1;
                default: out_ready = 1'($urandom_range(0, 1));
            endcase
        end
    end

    task automatic send(logic [SW-1:0] s, logic [EW-1:0] e, logic r, logic [1:0] a);
        in_sig = s; in_exp = e; in_rup = r; in_adj = a; in_valid = 1'b1;
        do @(negedge clk); while (!in_ready);
        @(posedge clk);
        #1;
        in_valid = 1'b0;
    endtask

    task automatic lat_case(logic [SW-1:0] s, logic [EW-1:0] e, logic r, logic [1:0] a, string req);
        int k = 0;
        int want;
        cur_req = req;
        want = r ? digits(s) : 0;
        send(s, e, r, a);
        forever begin
            @(negedge clk);
            if (out_valid || k > 100) break;
            k++;
        end
        check(k == want, "R8", "latency", 64'(k), 64'(want));
        @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(in_ready == 1'b1, "R9", "in_ready in reset", 64'(in_ready), 64'(1));
        check(out_valid == 1'b0, "R9", "out_valid in reset", 64'(out_valid), 64'(0));
        @(posedge clk);
        #1;
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        @(negedge clk);
        check(in_ready == 1'b1 && out_valid == 1'b0, "R9", "idle after reset",
              64'({in_ready, out_valid}), 64'(2));
        @(posedge clk);
        #1;

        // Significand increment and latency
        lat_case(53'h0, 11'd100, 1'b0, 2'b00, "R4");
        lat_case(53'h12345, 11'd100, 1'b0, 2'b00, "R4");
        lat_case(53'h10, 11'd100, 1'b1, 2'b00, "R4");
        lat_case(53'h3, 11'd100, 1'b1, 2'b00, "R4");
        lat_case(53'h3FF, 11'd100, 1'b1, 2'b00, "R4");
        lat_case(53'h0F_FFFF_FFFF, 11'd900, 1'b1, 2'b00, "R4");
        lat_case({1'b0, {52{1'b1}}}, 11'd900, 1'b1, 2'b00, "R4");
        lat_case({SW{1'b1}}, 11'd500, 1'b1, 2'b00, "R5");
        lat_case({SW{1'b1}}, 11'd500, 1'b0, 2'b00, "R5");
        // Exponent code
        lat_case(53'h55, 11'd10, 1'b0, 2'b01, "R6");
        lat_case(53'h55, 11'd10, 1'b0, 2'b10, "R6");
        lat_case(53'h55, 11'd0, 1'b0, 2'b10, "R6");
        lat_case({SW{1'b1}}, 11'd0, 1'b1, 2'b10, "R6");
        lat_case(53'h55, 11'd0, 1'b0, 2'b00, "R6");
        // Saturation
        lat_case(53'h7, 11'd2045, 1'b0, 2'b01, "R7");
        lat_case(53'h7, 11'd2046, 1'b0, 2'b01, "R7");
        lat_case(53'h7, 11'd2047, 1'b0, 2'b00, "R7");
        lat_case({SW{1'b1}}, 11'd2046, 1'b1, 2'b00, "R7");
        lat_case({SW{1'b1}}, 11'd2045, 1'b1, 2'b00, "R7");
        lat_case({SW{1'b1}}, 11'd2046, 1'b1, 2'b10, "R7");

        // Backpressure: two in flight, third held off
        cur_req = "R2";
        rdy_mode = 0;
        @(posedge clk);
        #1;
        send({SW{1'b1}}, 11'd20, 1'b1, 2'b00);
        send(53'h4, 11'd30, 1'b1, 2'b01);
        in_sig = 53'h9; in_exp = 11'd40; in_rup = 1'b0; in_adj = 2'b10; in_valid = 1'b1;
        repeat (40) @(posedge clk);
        @(negedge clk);
        check(in_ready == 1'b0, "R2", "third op blocked", 64'(in_ready), 64'(0));
        check(out_valid == 1'b1 && out_sig == {1'b1, {(SW-1){1'b0}}}, "R1",
              "oldest result presented", 64'(out_sig), 64'({1'b1, {(SW-1){1'b0}}}));
        rdy_mode = 1;
        do @(negedge clk); while (!in_ready);
        @(posedge clk);
        #1;
        in_valid = 1'b0;
        repeat (10) @(posedge clk);
        #1;

        // Random stream with random stalls
        cur_req = "R3";
        rdy_mode = 2;
        for (int n = 0; n < 1500; n++) begin
            logic [63:0]   rnd;
            logic [SW-1:0] s;
            logic [EW-1:0] e;
            logic [1:0]    a;
            int            kind;
            rnd  = {$urandom(), $urandom()};
            s    = rnd[SW-1:0];
            kind = $urandom_range(0, 3);
            if (kind == 1) s = s | ((SW'(1) << $urandom_range(0, SW - 1)) - SW'(1));
            if (kind == 2) s = {SW{1'b1}};
            e = ($urandom_range(0, 3) == 0) ? EW'($urandom_range(EMAX - 3, EMAX))
                                            : EW'($urandom_range(0, EMAX));
            a = 2'($urandom_range(0, 2));
            send(s, e, 1'($urandom_range(0, 1)), a);
        end
        rdy_mode = 1;
        for (int w = 0; w < 200 && exp_q.size() != 0; w++) @(posedge clk);
        @(negedge clk);
        check(exp_q.size() == 0, "R3", "all results delivered", 64'(exp_q.size()), 64'(0));

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            finished = 1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

endmodule